// File: doc/BRIEF.md
# Daisy-Chain Command Frame Receiver

This block is the receive-side command decoder for one chip in a string of chips that share one serial command line. Bytes come in one at a time from an upstream byte interface (`in_valid`/`in_data`). The block hunts for the two-byte sync pattern, reads the command and length bytes, and collects the rest of the frame while it runs a 5-bit CRC over it. When the frame is complete and the CRC matches, it carries out one of four short commands: set-address, register write, register read or chain-inactive.

The chip keeps a logical address and a relay flag. The relay flag gates the chain input onto the chain output. The host numbers the chain as follows. It first silences every relay with a broadcast chain-inactive. It then sends a series of set-address frames. Each frame is taken by the one chip that has no address yet, and that chip then opens its relay so the next frame's enable reaches its neighbour. Register writes leave on a one-cycle write strobe. Register reads raise a one-cycle request carrying the register index. Job frames, the serial line coding and response transmission belong to other blocks.

Top module: `chn_cmd_rx`

## Requirements
- R1: A frame begins only after a byte 0x55 followed directly by a byte 0xAA, counting only bytes taken with `in_valid` high. All other bytes are skipped while hunting. A run of 0x55 bytes before the 0xAA still synchronises. Idle cycles with `in_valid` low may fall anywhere inside a frame.
- R2: The byte after the command byte is the length. It counts the bytes from the command byte through the CRC byte: 5 for a short frame, and 5+DATA_BYTES (9 by default) for a write. Any other value abandons the frame without an error pulse and restarts the hunt.
- R3: The CRC uses polynomial x^5+x^2+1 with initial value 0x1F and takes bits most significant first. It covers every byte from the command byte up to the byte before the last one. The last byte must equal {3'b000, crc}. On a mismatch the frame has no effect and `crc_err` is high for exactly one cycle.
- R4: Command byte bit 4 is the broadcast flag. With that bit cleared, the code selects 0x40 set-address, 0x41 write, 0x42 read or 0x43 chain-inactive. A write acts only with the long length, and the other three act only with length 5. Any other code, or any other length for the code, is ignored.
- R5: If the broadcast flag is clear, a write, read or chain-inactive takes effect only when the chip has an address and frame byte 4 equals that address.
- R6: An accepted write gives one `wr_en` pulse of one cycle. It carries `wr_idx` = frame byte 5 and `wr_data` = bytes 6 to 9 with byte 6 as the most significant.
- R7: An accepted read gives one `rd_req` pulse of one cycle, with `rd_idx` = frame byte 5.
- R8: An accepted chain-inactive clears the relay flag, so `chain_out` stays low whatever `chain_in` does.
- R9: A set-address frame is taken only while `addr_valid` is low. When taken, it stores byte 4 in `chip_addr`, sets `addr_valid` and sets the relay flag. Later set-address frames change nothing.
- R10: After reset, `addr_valid` and `chip_addr` are 0, the relay flag is set, and `wr_en`, `rd_req` and `crc_err` are low.
- R11: `chain_out` equals `chain_in` AND the relay flag, with no register in the path.
- R12: After a CRC error the parser is back in hunt, and a good frame that follows at once is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe from the upstream byte interface |
| in_data | input | 8 | Received byte |
| chain_in | input | 1 | Chain enable from the upstream chip |
| chain_out | output | 1 | Chain enable to the downstream chip |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 8 | Register index of the write |
| wr_data | output | 8*DATA_BYTES | Register write value |
| rd_req | output | 1 | Register read request strobe |
| rd_idx | output | 8 | Register index of the read |
| crc_err | output | 1 | One-cycle pulse on a CRC mismatch |
| chip_addr | output | 8 | Stored logical address |
| addr_valid | output | 1 | Chip has been given an address |

## Verification
The bench builds the block with the default DATA_BYTES of 4. This gives 7-byte short frames and 11-byte write frames with a 32-bit value, so the full enumeration sequence can be run end to end. With these lengths, a length byte that fits neither frame type can be sent on purpose, and so can a correctly checksummed write that carries the short length. The bench computes every CRC itself in shift-register form. It then drives broadcast and directed frames before and after the chip has an address, which covers both sides of the address-match rule and the one-shot set-address behaviour.

// File: rtl/chn_cmd_pkg.sv
package chn_cmd_pkg;

  localparam logic [7:0] SYNC_A    = 8'h55;
  localparam logic [7:0] SYNC_B    = 8'hAA;
  localparam int         SHORT_LEN = 5;
  localparam int         BCAST_POS = 4;
  localparam logic [4:0] CRC_SEED  = 5'h1F;
  localparam logic [5:0] CMD_GROUP = 6'b010000;

  typedef enum logic [2:0] {
    PS_HUNT_A,
    PS_HUNT_B,
    PS_CMD,
    PS_LEN,
    PS_BODY
  } pstate_t;

  typedef enum logic [1:0] {
    OP_SETADDR  = 2'd0,
    OP_WRITE    = 2'd1,
    OP_READ     = 2'd2,
    OP_INACTIVE = 2'd3
  } op_t;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] len;
    logic [7:0] dst;
    logic [7:0] idx;
  } hdr_t;

  // x^5+x^2+1, MSB first, one byte per call
  function automatic logic [4:0] crc5_next(input logic [4:0] c, input logic [7:0] b);
    logic [4:0] r;
    logic       fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[4] ^ b[i];
      r  = {r[3], r[2], r[1] ^ fb, r[0], fb};
    end
    return r;
  endfunction

endpackage

// File: rtl/chn_crc5_acc.sv
module chn_crc5_acc
  import chn_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       en,
  input  logic [7:0] din,
  output logic [4:0] crc
);

  logic [4:0] crc_q;
  logic [4:0] base;

  assign base = start ? CRC_SEED : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (en) begin
      crc_q <= crc5_next(base, din);
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/chn_frame_parser.sv
module chn_frame_parser
  import chn_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    frm_ok,
  output logic                    crc_err,
  output hdr_t                    hdr,
  output logic [8*DATA_BYTES-1:0] payload
);

  localparam int         DATA_W   = 8 * DATA_BYTES;
  localparam int         LONG_LEN = SHORT_LEN + DATA_BYTES;
  localparam int         CNT_W    = $clog2(LONG_LEN + 1);
  localparam logic [7:0] LEN_S    = 8'(SHORT_LEN);
  localparam logic [7:0] LEN_L    = 8'(LONG_LEN);

  pstate_t            state_q;
  hdr_t               hdr_q;
  logic [DATA_W-1:0]  data_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ok_q;
  logic               err_q;

  logic               byte_take;
  logic               len_bad;
  logic               body_last;
  logic               crc_match;
  logic               crc_start;
  logic               crc_en;
  logic [4:0]         crc_now;

  assign byte_take = in_valid;
  assign len_bad   = byte_take && (state_q == PS_LEN) &&
                     (in_data != LEN_S) && (in_data != LEN_L);
  assign body_last = (cnt_q == CNT_W'(hdr_q.len - 8'd3));
  assign crc_match = (in_data == {3'b000, crc_now});
  assign crc_start = (state_q == PS_CMD);
  assign crc_en    = byte_take && ((state_q == PS_CMD) || (state_q == PS_LEN) ||
                                   ((state_q == PS_BODY) && !body_last));

  chn_crc5_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .start (crc_start),
    .en    (crc_en),
    .din   (in_data),
    .crc   (crc_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PS_HUNT_A;
      hdr_q   <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (byte_take) begin
        unique case (state_q)
          PS_HUNT_A: begin
            if (in_data == SYNC_A) state_q <= PS_HUNT_B;
          end
          PS_HUNT_B: begin
            if (in_data == SYNC_B)      state_q <= PS_CMD;
            else if (in_data != SYNC_A) state_q <= PS_HUNT_A;
          end
          PS_CMD: begin
            hdr_q.cmd <= in_data;
            state_q   <= PS_LEN;
          end
          PS_LEN: begin
            hdr_q.len <= in_data;
            cnt_q     <= '0;
            state_q   <= len_bad ? PS_HUNT_A : PS_BODY;
          end
          PS_BODY: begin
            if (body_last) begin
              ok_q    <= crc_match;
              err_q   <= !crc_match;
              state_q <= PS_HUNT_A;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == '0)
                hdr_q.dst <= in_data;
              else if (cnt_q == CNT_W'(1))
                hdr_q.idx <= in_data;
              else
                data_q <= {data_q[DATA_W-9:0], in_data};
            end
          end
          default: state_q <= PS_HUNT_A;
        endcase
      end
    end
  end

  assign frm_ok  = ok_q;
  assign crc_err = err_q;
  assign hdr     = hdr_q;
  assign payload = data_q;

  // R1
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PS_CMD) && ($past(state_q) != PS_CMD)) |->
      ($past(in_data) == SYNC_B && $past(in_valid)));

  // R2
  len_bad_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_bad |=> (state_q == PS_HUNT_A) && !crc_err);

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> !crc_err);

  // R3
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_ok && crc_err));

  // R12
  err_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> (state_q == PS_HUNT_A));

endmodule

// File: rtl/chn_cmd_exec.sv
module chn_cmd_exec
  import chn_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frm_ok,
  input  hdr_t                    hdr,
  input  logic [8*DATA_BYTES-1:0] payload,
  output logic                    relay_en,
  output logic [7:0]              chip_addr,
  output logic                    addr_valid,
  output logic                    wr_en,
  output logic [7:0]              wr_idx,
  output logic [8*DATA_BYTES-1:0] wr_data,
  output logic                    rd_req,
  output logic [7:0]              rd_idx
);

  localparam int         DATA_W = 8 * DATA_BYTES;
  localparam logic [7:0] LEN_S  = 8'(SHORT_LEN);
  localparam logic [7:0] LEN_L  = 8'(SHORT_LEN + DATA_BYTES);

  logic [7:0]        base_code;
  logic              bcast;
  logic              known;
  op_t               op;
  logic              len_fit;
  logic              targeted;
  logic              set_hit;
  logic              wr_hit;
  logic              rd_hit;
  logic              inact_hit;

  logic              relay_q;
  logic [7:0]        addr_q;
  logic              valid_q;
  logic              wr_q;
  logic [7:0]        wr_idx_q;
  logic [DATA_W-1:0] wr_data_q;
  logic              rd_q;
  logic [7:0]        rd_idx_q;

  always_comb begin
    base_code = hdr.cmd;
    base_code[BCAST_POS] = 1'b0;
    bcast     = hdr.cmd[BCAST_POS];
    known     = (base_code[7:2] == CMD_GROUP);
    op        = op_t'(base_code[1:0]);
    len_fit   = (op == OP_WRITE) ? (hdr.len == LEN_L) : (hdr.len == LEN_S);
    targeted  = bcast || (valid_q && (hdr.dst == addr_q));
  end

  assign set_hit   = frm_ok && known && len_fit && (op == OP_SETADDR) && !valid_q;
  assign wr_hit    = frm_ok && known && len_fit && (op == OP_WRITE) && targeted;
  assign rd_hit    = frm_ok && known && len_fit && (op == OP_READ) && targeted;
  assign inact_hit = frm_ok && known && len_fit && (op == OP_INACTIVE) && targeted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      relay_q   <= 1'b1;
      addr_q    <= '0;
      valid_q   <= 1'b0;
      wr_q      <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      rd_q      <= 1'b0;
      rd_idx_q  <= '0;
    end else begin
      wr_q <= wr_hit;
      rd_q <= rd_hit;
      if (wr_hit) begin
        wr_idx_q  <= hdr.idx;
        wr_data_q <= payload;
      end
      if (rd_hit) rd_idx_q <= hdr.idx;
      if (set_hit) begin
        addr_q  <= hdr.dst;
        valid_q <= 1'b1;
        relay_q <= 1'b1;
      end else if (inact_hit) begin
        relay_q <= 1'b0;
      end
    end
  end

  assign relay_en   = relay_q;
  assign chip_addr  = addr_q;
  assign addr_valid = valid_q;
  assign wr_en      = wr_q;
  assign wr_idx     = wr_idx_q;
  assign wr_data    = wr_data_q;
  assign rd_req     = rd_q;
  assign rd_idx     = rd_idx_q;

  // R9
  addr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> addr_valid && $stable(chip_addr));

  // R9
  set_opens_relay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> relay_en && addr_valid);

  // R8
  inactive_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inact_hit |=> !relay_en);

  // R6
  wr_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(frm_ok));

  // R7
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req));

endmodule

// File: rtl/chn_cmd_rx.sv
module chn_cmd_rx
  import chn_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  input  logic                    chain_in,
  output logic                    chain_out,
  output logic                    wr_en,
  output logic [7:0]              wr_idx,
  output logic [8*DATA_BYTES-1:0] wr_data,
  output logic                    rd_req,
  output logic [7:0]              rd_idx,
  output logic                    crc_err,
  output logic [7:0]              chip_addr,
  output logic                    addr_valid
);

  logic                    frm_ok;
  hdr_t                    hdr;
  logic [8*DATA_BYTES-1:0] payload;
  logic                    relay_en;

  chn_frame_parser #(.DATA_BYTES(DATA_BYTES)) u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .frm_ok   (frm_ok),
    .crc_err  (crc_err),
    .hdr      (hdr),
    .payload  (payload)
  );

  chn_cmd_exec #(.DATA_BYTES(DATA_BYTES)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_ok     (frm_ok),
    .hdr        (hdr),
    .payload    (payload),
    .relay_en   (relay_en),
    .chip_addr  (chip_addr),
    .addr_valid (addr_valid),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .rd_idx     (rd_idx)
  );

  assign chain_out = chain_in & relay_en;

  // R11
  relay_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_in) |-> !chain_out);

endmodule

// File: tb/chn_cmd_rx_bench.sv
module chn_cmd_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        chain_in = 1'b1;
  logic        chain_out;
  logic        wr_en;
  logic [7:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rd_req;
  logic [7:0]  rd_idx;
  logic        crc_err;
  logic [7:0]  chip_addr;
  logic        addr_valid;

  int n_chk = 0;
  int n_bad = 0;
  int n_wr = 0;
  int n_rd = 0;
  int n_err = 0;
  logic [7:0]  got_widx;
  logic [31:0] got_wdata;
  logic [7:0]  got_ridx;
  logic [7:0]  fb [0:10];

  always #4 clk = ~clk;

  chn_cmd_rx u_chn_cmd_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .chain_in(chain_in), .chain_out(chain_out), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_req(rd_req), .rd_idx(rd_idx), .crc_err(crc_err),
    .chip_addr(chip_addr), .addr_valid(addr_valid)
  );

  always @(negedge clk) begin
    if (wr_en) begin n_wr++; got_widx = wr_idx; got_wdata = wr_data; end
    if (rd_req) begin n_rd++; got_ridx = rd_idx; end
    if (crc_err) n_err++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_crc(input int first, input int last);
    logic [4:0] c = 5'h1F;
    for (int k = first; k <= last; k++)
      for (int j = 7; j >= 0; j--) begin
        logic top = c[4] ^ fb[k][j];
        c = {c[3:0], 1'b0};
        if (top) c = c ^ 5'h05;
      end
    return c;
  endfunction

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_wr = 0; n_rd = 0; n_err = 0;
  endtask

  task automatic send(input logic [7:0] cmd, input logic [7:0] len, input logic [7:0] dst,
                      input logic [7:0] idx, input logic [31:0] val, input bit bad, input bit gaps);
    int n;
    fb[0] = 8'h55; fb[1] = 8'hAA; fb[2] = cmd; fb[3] = len;
    if (len == 8'd5 || len == 8'd9) begin
      fb[4] = dst; fb[5] = idx;
      if (len == 8'd9) begin
        fb[6] = val[31:24]; fb[7] = val[23:16]; fb[8] = val[15:8]; fb[9] = val[7:0];
      end
      n = int'(len) + 2;
      fb[n-1] = {3'b000, ref_crc(2, n - 2)} ^ (bad ? 8'h01 : 8'h00);
    end else begin
      n = 4;
    end
    for (int k = 0; k < n; k++) begin
      put(fb[k]);
      if (gaps && (k % 2 == 1)) idle(1);
    end
    idle(4);
  endtask

  task automatic t_reset();
    check("R10 addr_valid", 32'(addr_valid), 0);
    check("R10 chip_addr", 32'(chip_addr), 0);
    check("R10 strobes", {29'd0, wr_en, rd_req, crc_err}, 0);
    chain_in = 1'b1; #1;
    check("R10 relay on / R11 chain_out", 32'(chain_out), 1);
    chain_in = 1'b0; #1;
    check("R11 chain_out low", 32'(chain_out), 0);
    chain_in = 1'b1;
  endtask

  task automatic t_unaddressed();
    clear_counts();
    send(8'h42, 8'd5, 8'h00, 8'h1C, 0, 0, 0);
    check("R5 directed read on unaddressed chip", 32'(n_rd), 0);
    send(8'h52, 8'd5, 8'h00, 8'h00, 0, 0, 0);
    check("R7 broadcast read count", 32'(n_rd), 1);
    check("R7 rd_idx", 32'(got_ridx), 32'h00);
  endtask

  task automatic t_hunt();
    clear_counts();
    put(8'h12); put(8'hAA); put(8'h55); put(8'h55);
    send(8'h52, 8'd5, 8'h00, 8'h2C, 0, 0, 0);
    check("R1 sync after 55 run", 32'(n_rd), 1);
    check("R1 rd_idx", 32'(got_ridx), 32'h2C);
    send(8'h51, 8'd9, 8'h00, 8'h80, 32'h1234_5678, 0, 1);
    check("R1 gapped write count", 32'(n_wr), 1);
    check("R1 gapped write data", got_wdata, 32'h1234_5678);
  endtask

  task automatic t_len();
    clear_counts();
    put(8'h55); put(8'hAA); put(8'h52); put(8'h07);
    send(8'h52, 8'd5, 8'h00, 8'h11, 0, 0, 0);
    check("R2 bad length then good frame", 32'(n_rd), 1);
    check("R2 rd_idx", 32'(got_ridx), 32'h11);
    check("R2 no error pulse", 32'(n_err), 0);
  endtask

  task automatic t_crc();
    clear_counts();
    send(8'h51, 8'd9, 8'h00, 8'h44, 32'hCAFE_0001, 1, 0);
    check("R3 corrupted write dropped", 32'(n_wr), 0);
    check("R3 one-cycle crc_err", 32'(n_err), 1);
    send(8'h52, 8'd5, 8'h00, 8'h21, 0, 0, 0);
    check("R12 good frame after error", 32'(n_rd), 1);
    check("R12 rd_idx", 32'(got_ridx), 32'h21);
  endtask

  task automatic t_bad_op();
    clear_counts();
    send(8'h44, 8'd5, 8'h00, 8'h01, 0, 0, 0);
    send(8'h51, 8'd5, 8'h00, 8'h02, 0, 0, 0);
    send(8'h52, 8'd9, 8'h00, 8'h03, 32'h0, 0, 0);
    check("R4 ignored writes", 32'(n_wr), 0);
    check("R4 ignored reads", 32'(n_rd), 0);
    check("R4 no crc error", 32'(n_err), 0);
    check("R4 relay untouched", 32'(chain_out), 1);
  endtask

  task automatic t_enumerate();
    send(8'h53, 8'd5, 8'h00, 8'h00, 0, 0, 0);
    check("R8 broadcast inactive", 32'(chain_out), 0);
    send(8'h40, 8'd5, 8'h08, 8'h00, 0, 0, 0);
    check("R9 chip_addr", 32'(chip_addr), 32'h08);
    check("R9 addr_valid", 32'(addr_valid), 1);
    check("R9 relay reopened", 32'(chain_out), 1);
    send(8'h40, 8'd5, 8'h22, 8'h00, 0, 0, 0);
    check("R9 second set ignored", 32'(chip_addr), 32'h08);
    send(8'h43, 8'd5, 8'h09, 8'h00, 0, 0, 0);
    check("R5 inactive other chip", 32'(chain_out), 1);
    send(8'h43, 8'd5, 8'h08, 8'h00, 0, 0, 0);
    check("R8 directed inactive", 32'(chain_out), 0);
    chain_in = 1'b0; #1; chain_in = 1'b1; #1;
    check("R8 chain_out held low", 32'(chain_out), 0);
  endtask

  task automatic t_directed();
    clear_counts();
    send(8'h41, 8'd9, 8'h08, 8'h18, 32'h0000_7A31, 0, 0);
    check("R6 directed write count", 32'(n_wr), 1);
    check("R6 wr_idx", 32'(got_widx), 32'h18);
    check("R6 wr_data", got_wdata, 32'h0000_7A31);
    send(8'h41, 8'd9, 8'h09, 8'h18, 32'h1111_1111, 0, 0);
    check("R5 write other chip", 32'(n_wr), 1);
    send(8'h42, 8'd5, 8'h08, 8'h1C, 0, 0, 0);
    check("R7 directed read", 32'(n_rd), 1);
    check("R7 rd_idx", 32'(got_ridx), 32'h1C);
    send(8'h51, 8'd9, 8'h33, 8'h80, 32'hDEAD_BEEF, 0, 0);
    check("R6 broadcast write count", 32'(n_wr), 2);
    check("R6 broadcast data", got_wdata, 32'hDEAD_BEEF);
    check("R6 broadcast idx", 32'(got_widx), 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unaddressed();
    t_hunt();
    t_len();
    t_crc();
    t_bad_op();
    t_enumerate();
    t_directed();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule